// File: doc/BRIEF.md
# Paged Nonvolatile Write Controller

This block is a clocked model of the write side of a byte-wide paged nonvolatile memory that a host reaches like an SRAM. The host uses active-low chip-enable, write-enable and output-enable strobes. The block samples these strobes on its clock, finds the start and end of each write pulse, and turns a valid pulse into one byte load. A write pulse runs while chip-enable and write-enable are both low. The address is taken in the first cycle of the pulse. The data is taken in the last cycle of the pulse.

The first byte that is accepted opens a load window for its page. The page is held in the upper address bits, and each page holds 256 bytes. Further bytes for the same page can arrive in any order, and a byte can be written again before the window closes. If no byte arrives for a set number of cycles, the window closes and a program timer starts. When the timer ends, only the bytes marked during loading are written into the storage array. The block has read access through the same strobes, so the host can see the stored contents.

The noise-filter width, the byte-load gap limit, the program time and the power-on hold-off are all parameters counted in clock cycles. The address width is also a parameter. Its default is 12 bits, which gives 16 pages and keeps the behavioural array small.

Top module: `pnv_write_ctrl`

## Requirements
- R1: After reset, `busy` and `page_err` are 0.
- R2: A write pulse that ends within the first POR_CYC clock edges after reset is ignored: `busy` stays 0.
- R3: A write pulse is a run of cycles with `ce_n`=0 and `we_n`=0. The address comes from its first cycle and the data from its last cycle. The pulse is accepted on the clock edge where the strobes are first seen released.
- R4: A pulse shorter than FILT_CYC cycles is ignored.
- R5: A pulse during which `oe_n` is low in any cycle is ignored.
- R6: `busy` rises on the edge that accepts the first byte. The window closes BLC_CYC edges after the last accepted byte. `busy` then stays high for WC_CYC more edges and falls on the edge that commits the page.
- R7: Bytes of one page (address bits above bit 7) may load in any order. The last value loaded for an offset (bits 7..0) wins. Only the offsets that were loaded change in storage.
- R8: During a load window, a pulse for a different page is ignored and sets `page_err`. `page_err` stays set until reset.
- R9: A pulse accepted after the window has closed, while programming runs, has no effect on storage and does not set `page_err`.
- R10: When `ce_n`=0, `oe_n`=0 and `we_n`=1, `dout_vld` is 1 and `dout` shows the stored byte at `addr`. Otherwise both are 0.
- R11: Storage keeps its old contents until the commit edge, so reads while `busy` is high return the old data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; bits 7..0 are the offset and the upper bits are the page |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when no read is active |
| dout_vld | output | 1 | A read is active |
| busy | output | 1 | A load window or programming is in progress |
| page_err | output | 1 | Sticky flag for a page-mismatch write |

## Verification
Most internal faults show up first in the timing of `busy`. A gap or program counter that is off by one moves the falling edge of `busy` by a cycle. The reference model compares `busy` on every clock, so that edge catches it at once. Errors in the valid flags, the page latch or the point where data is captured show up only after the commit edge. They appear as a wrong byte on `dout` at the next read of the affected offsets, or of the untouched neighbours of those offsets. A wrong filter, inhibit or power-on gate shows up when `busy` rises after a pulse that should have been ignored.

// File: rtl/pnv_write_ctrl.sv
module pnv_write_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int OFF_W    = 8,
  parameter int FILT_CYC = 2,
  parameter int BLC_CYC  = 7500,
  parameter int WC_CYC   = 500000,
  parameter int POR_CYC  = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_vld,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int NBYTES = 1 << OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int FW     = $clog2(FILT_CYC + 1);
  localparam int GW     = $clog2(BLC_CYC + 1);
  localparam int PW     = $clog2(WC_CYC + 1);
  localparam int RW     = $clog2(POR_CYC + 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_LOAD = 2'd1, S_PROG = 2'd2} st_t;

  st_t               st;
  logic              strb, strb_q, ok_q;
  logic [FW-1:0]     len_q;
  logic [ADDR_W-1:0] adr_q;
  logic [7:0]        dat_q;
  logic [RW-1:0]     por_q;
  logic [GW-1:0]     gap_q;
  logic [PW-1:0]     prog_q;
  logic [PAGE_W-1:0] page_q;
  logic [NBYTES-1:0] vld_q;
  logic [7:0]        pbuf [NBYTES];
  logic [7:0]        mem  [DEPTH];
  logic              err_q;

  assign strb = ~ce_n & ~we_n;

  wire              por_done  = (por_q == RW'(POR_CYC));
  wire              acc       = strb_q & ~strb & ok_q & (len_q >= FW'(FILT_CYC));
  wire [PAGE_W-1:0] a_pg      = adr_q[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0]  a_off     = adr_q[OFF_W-1:0];
  wire              take_new  = acc & por_done & (st == S_IDLE);
  wire              take_more = acc & (st == S_LOAD) & (a_pg == page_q);
  wire              commit    = (st == S_PROG) & (prog_q == PW'(WC_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      ok_q   <= 1'b0;
      len_q  <= '0;
      adr_q  <= '0;
      dat_q  <= '0;
    end else begin
      strb_q <= strb;
      if (strb) dat_q <= din;
      if (strb && !strb_q) begin
        len_q <= FW'(1);
        ok_q  <= oe_n;
        adr_q <= addr;
      end else if (strb) begin
        ok_q <= ok_q & oe_n;
        if (len_q != FW'(FILT_CYC)) len_q <= len_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_q <= '0;
    else if (!por_done) por_q <= por_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      gap_q  <= '0;
      prog_q <= '0;
      page_q <= '0;
      vld_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take_new) begin
          st           <= S_LOAD;
          page_q       <= a_pg;
          vld_q        <= '0;
          vld_q[a_off] <= 1'b1;
          gap_q        <= '0;
        end
        S_LOAD: if (take_more) begin
          vld_q[a_off] <= 1'b1;
          gap_q        <= '0;
        end else begin
          if (acc) err_q <= 1'b1;
          if (gap_q == GW'(BLC_CYC - 1)) begin
            st     <= S_PROG;
            prog_q <= '0;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        S_PROG: if (commit) st <= S_IDLE;
                else prog_q <= prog_q + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take_new || take_more) pbuf[a_off] <= dat_q;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (vld_q[i]) mem[{page_q, OFF_W'(i)}] <= pbuf[i];
      end
    end
  end

  assign busy     = (st != S_IDLE);
  assign page_err = err_q;
  assign dout_vld = ~ce_n & ~oe_n & we_n;
  assign dout     = dout_vld ? mem[addr] : 8'h00;
endmodule

// File: rtl/pnv_write_ctrl_chk.sv
module pnv_write_ctrl_chk #(
  parameter int PAGE_W   = 4,
  parameter int FW       = 2,
  parameter int GW       = 13,
  parameter int FILT_CYC = 2,
  parameter int BLC_CYC  = 7500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              busy,
  input logic              page_err,
  input logic              por_done,
  input logic [1:0]        st,
  input logic [PAGE_W-1:0] page_q,
  input logic [GW-1:0]     gap_q,
  input logic [FW-1:0]     len_q
);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) page_err |=> page_err);
  // R2
  por_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(por_done));
  // R4
  filter_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> ($past(len_q) >= FW'(FILT_CYC)));
  // R3
  release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(ce_n | we_n));
  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd1 && $past(st) == 2'd1) |-> $stable(page_q));
  // R6
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) gap_q < GW'(BLC_CYC));
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> ($past(st) == 2'd2));
endmodule

bind pnv_write_ctrl pnv_write_ctrl_chk #(
  .PAGE_W(PAGE_W), .FW(FW), .GW(GW), .FILT_CYC(FILT_CYC), .BLC_CYC(BLC_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .busy(busy),
  .page_err(page_err), .por_done(por_done), .st(st), .page_q(page_q),
  .gap_q(gap_q), .len_q(len_q)
);

// File: tb/pnv_write_ctrl_tb.sv
module pnv_write_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 12, FILT = 2, BLC = 12, WC = 30, POR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_vld, busy, page_err;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  pnv_write_ctrl #(.ADDR_W(AW), .FILT_CYC(FILT), .BLC_CYC(BLC), .WC_CYC(WC), .POR_CYC(POR)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .din(din), .dout(dout), .dout_vld(dout_vld), .busy(busy), .page_err(page_err));

  // behavioural reference
  int cyc = 0, e_cnt = 0, mode = 0, m_close = 0, m_end = 0, m_page = 0, m_len = 0;
  bit m_prev = 0, m_ok = 0, m_err = 0;
  int m_adr = 0;
  logic [7:0] m_dat = 0;
  logic [7:0] m_buf [int];
  logic [7:0] m_mem [int];

  always @(posedge clk) begin
    bit a, acc, more;
    int pg, off;
    cyc++;
    if (!rst_n) begin
      e_cnt = 0; mode = 0; m_prev = 0; m_ok = 0; m_len = 0; m_err = 0;
    end else begin
      a   = !ce_n && !we_n;
      acc = m_prev && !a && m_ok && (m_len >= FILT);
      pg  = m_adr / 256;
      off = m_adr % 256;
      if (mode == 0) begin
        if (acc && e_cnt >= POR) begin
          mode = 1; m_page = pg; m_buf.delete(); m_buf[off] = m_dat; m_close = cyc + BLC;
        end
      end else if (mode == 1) begin
        more = acc && (pg == m_page);
        if (more) begin
          m_buf[off] = m_dat; m_close = cyc + BLC;
        end else begin
          if (acc) m_err = 1;
          if (cyc == m_close) begin mode = 2; m_end = cyc + WC; end
        end
      end else if (cyc == m_end) begin
        foreach (m_buf[k]) m_mem[m_page*256 + k] = m_buf[k];
        mode = 0;
      end
      if (a && !m_prev) begin m_len = 1; m_ok = oe_n; m_adr = int'(addr); end
      else if (a) begin m_len++; m_ok = m_ok && oe_n; end
      if (a) m_dat = din;
      m_prev = a;
      e_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      bit rv;
      rv = !ce_n && !oe_n && we_n;
      chk(busy == (mode != 0), "R6 busy", busy, mode != 0);
      chk(page_err == m_err, "R8 page_err", page_err, m_err);
      chk(dout_vld == rv, "R10 dout_vld", dout_vld, rv);
      if (rv && m_mem.exists(int'(addr)))
        chk(dout == m_mem[int'(addr)], "R10 dout", dout, m_mem[int'(addr)]);
      if (!rv) chk(dout == 8'h00, "R10 dout idle", dout, 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d, input int len);
    @(negedge clk);
    addr = AW'(a); din = 8'(d); oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (len) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk);
    addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 chk(dout_vld && dout == 8'(exp), req, dout, exp);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic finish_load;
    idle(BLC + WC + 4);
    chk(busy == 1'b0, "R6 done", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    #1 chk(busy == 0 && page_err == 0, "R1 reset", {busy, page_err}, 0);
    @(negedge clk) rst_n = 1'b1;

    // R2: pulse inside the power-on hold-off
    wr(12'h010, 8'h11, 3);
    idle(2);
    chk(busy == 1'b0, "R2 hold-off", busy, 0);
    idle(10);

    // R7: out-of-order loading and overwrite
    wr(12'h103, 8'hA3, 2); idle(1);
    wr(12'h100, 8'hA0, 2); idle(1);
    wr(12'h102, 8'hA2, 2); idle(1);
    wr(12'h101, 8'hA1, 2);
    chk(busy == 1'b1, "R6 busy high", busy, 1);
    wr(12'h102, 8'hB2, 3);
    finish_load();
    rd(12'h100, 8'hA0, "R7 b0");
    rd(12'h101, 8'hA1, "R7 b1");
    rd(12'h102, 8'hB2, "R7 overwrite");
    rd(12'h103, 8'hA3, "R7 b3");

    // R11 and R7: a single byte leaves its neighbours alone
    wr(12'h101, 8'h5A, 2);
    idle(BLC + 3);
    rd(12'h101, 8'hA1, "R11 old data while busy");
    finish_load();
    rd(12'h101, 8'h5A, "R7 single");
    rd(12'h100, 8'hA0, "R7 neighbour 0");
    rd(12'h102, 8'hB2, "R7 neighbour 2");

    // R8: page mismatch
    wr(12'h305, 8'h35, 2);
    finish_load();
    chk(page_err == 0, "R8 no err yet", page_err, 0);
    wr(12'h200, 8'h21, 2); idle(1);
    wr(12'h305, 8'h99, 2); idle(1);
    wr(12'h201, 8'h22, 2);
    finish_load();
    chk(page_err == 1, "R8 err set", page_err, 1);
    rd(12'h305, 8'h35, "R8 other page kept");
    rd(12'h200, 8'h21, "R8 b0");
    rd(12'h201, 8'h22, "R8 b1");

    // R4: short pulse
    wr(12'h305, 8'h77, 1);
    idle(3);
    chk(busy == 0, "R4 short ignored", busy, 0);
    rd(12'h305, 8'h35, "R4 data kept");

    // R5: OE low during pulse
    @(negedge clk);
    addr = 12'h305; din = 8'h78; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk) oe_n = 0;
    @(negedge clk) oe_n = 1;
    @(negedge clk) begin ce_n = 1; we_n = 1; end
    idle(3);
    chk(busy == 0, "R5 inhibited", busy, 0);
    rd(12'h305, 8'h35, "R5 data kept");

    // R3: address from first cycle, data from last
    @(negedge clk);
    addr = 12'h305; din = 8'h10; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk) begin addr = 12'h3FF; din = 8'h20; end
    @(negedge clk) din = 8'h30;
    @(negedge clk) din = 8'h9C;
    @(negedge clk) begin ce_n = 1; we_n = 1; end
    #1 chk(busy == 0, "R3 accept on release edge", busy, 0);
    @(posedge clk) #1 chk(busy == 1, "R3 busy after release", busy, 1);
    finish_load();
    rd(12'h305, 8'h9C, "R3 capture");

    // R9: pulse while programming
    wr(12'h400, 8'h41, 2); idle(1);
    wr(12'h401, 8'h40, 2);
    finish_load();
    wr(12'h400, 8'h43, 2);
    idle(BLC + 3);
    wr(12'h401, 8'h42, 2);
    finish_load();
    rd(12'h401, 8'h40, "R9 late byte dropped");
    rd(12'h400, 8'h43, "R9 window byte");
    chk(page_err == 1, "R9 err unchanged", page_err, 1);

    // R10: no read without OE
    @(negedge clk);
    ce_n = 0; oe_n = 1; we_n = 1; addr = 12'h400;
    #1 chk(dout_vld == 0 && dout == 0, "R10 oe high", dout, 0);
    @(negedge clk) ce_n = 1;
    idle(2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule